// File: doc/BRIEF.md
# Asynchronous Serial Framer with Selectable Stop Length

This block holds one transmitter and one receiver for 8-bit asynchronous serial frames. The line idles high. A frame is a low start bit, eight data bits sent least significant bit first, and then one or two high stop bits. A single configuration input picks the stop length, and both directions obey it. The transmitter uses it to decide how many stop bits it appends. The receiver uses it to decide how many stop bits it checks.

Timing comes from an external divider. It supplies a tick pulse at sixteen times the bit rate. The transmitter holds each bit for sixteen ticks. The receiver first passes the line through a two-flop synchronizer. It then takes a majority vote over three consecutive tick samples near the centre of each bit, starting with the start bit. This rejects short low glitches on an idle line and single-tick disturbances inside a bit. A checked stop bit found low raises a sticky framing-error status bit. Reading the status register clears that bit.

Top module: `uart_framer`

## Requirements
- R1: After reset, txd is high, ferr and tx_busy are 0, and tx_ready and rx_ready are low.
- R2: A write while idle makes txd low on the clock after the write. The frame is a start bit of 0, then wr_data least significant bit first, and each bit lasts 16 ticks.
- R3: The transmitter appends one stop bit (value 1) when two_stop is 0 and two when it is 1. On the clock after the last stop bit ends, tx_busy is 0 and tx_ready pulses high for exactly one cycle.
- R4: A write while tx_busy is 1 is ignored. The frame in progress is unchanged, and no second frame follows it.
- R5: The receiver accepts a start bit only when the majority of three tick samples near its centre are low. A low pulse of two ticks on an idle line produces no rx_ready.
- R6: Each data bit is the majority of three consecutive tick samples near its centre, so a one-tick glitch inside a bit does not change the received byte.
- R7: With two_stop 0, only the first stop bit is checked. The receiver is ready for a new start bit right after that stop bit, so frames sent back to back with one stop bit are all received.
- R8: With two_stop 1, both stop bits are checked, and either one being low sets ferr. After a low stop bit, the receiver waits for the line to return high before it looks for a new start.
- R9: At the end of every frame, rx_data holds the byte and rx_ready pulses for one cycle, even when a framing error is flagged. ferr rises in that same cycle.
- R10: ferr is 0 on the clock after a cycle with stat_rd high, unless a new framing error is set at that same clock, in which case ferr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| wr_en | input | 1 | Write strobe for a byte to transmit |
| wr_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe; clears ferr |
| tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Status: frame being sent |
| tx_ready | output | 1 | One-cycle pulse when a frame has been sent |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | One-cycle pulse when a byte is received |
| ferr | output | 1 | Status: sticky framing error |

## Verification
Transmit results are counted in ticks from the write clock. The start bit appears on the first clock after the write. Each bit boundary falls on the sixteenth tick of that bit, and tx_ready rises on the clock after the last boundary. The checks therefore sample txd eight ticks into each bit and look for tx_ready on the clock after the final boundary. Receive results appear at the centre of the last checked stop bit, and that point moves with the stop setting. The bench does not predict that clock. It queues the expected byte and error flag, and then compares rx_data and ferr on whichever clock rx_ready pulses. It recomputes the ferr value on every clock from the previous clock's stat_rd, and a set takes precedence over a clear.

// File: rtl/uart_framer.sv
module uart_framer #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_stop,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          tick,
  input  logic          rxd,
  output logic          txd,
  output logic          tx_busy,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ferr
);
  localparam int CW = $clog2(OSR);
  localparam int LW = $clog2(DW + 4);
  localparam int IW = $clog2(DW);

  // transmitter
  logic [DW+1:0] tx_sh;
  logic [LW-1:0] tx_left;
  logic [CW-1:0] tx_cnt;

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_sh    <= '1;
      tx_left  <= '0;
      tx_cnt   <= '0;
      tx_ready <= 1'b0;
    end else begin
      tx_ready <= 1'b0;
      if (!tx_busy) begin
        if (wr_en) begin
          tx_busy <= 1'b1;
          tx_sh   <= {2'b11, wr_data, 1'b0};
          tx_left <= LW'(DW + 2) + LW'(two_stop);
          tx_cnt  <= '0;
        end
      end else if (tick) begin
        if (tx_cnt == CW'(OSR - 1)) begin
          tx_cnt  <= '0;
          tx_sh   <= {1'b1, tx_sh[DW+1:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == LW'(1)) begin
            tx_busy  <= 1'b0;
            tx_ready <= 1'b1;
          end
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  // receiver
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP1, R_STOP2, R_WAIT} rx_st_t;
  rx_st_t        rst;
  logic          rs1, rs2;
  logic [1:0]    hist;
  logic [CW-1:0] rcnt;
  logic [IW-1:0] rbit;
  logic [DW-1:0] rsh;
  logic          bad1;
  logic          vote;
  logic          mid;

  assign vote = (hist[1] & hist[0]) | (hist[1] & rs2) | (hist[0] & rs2);
  assign mid  = tick && (rst == R_START ? rcnt == CW'(OSR/2 - 1) : rcnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1      <= 1'b1;
      rs2      <= 1'b1;
      hist     <= 2'b11;
      rst      <= R_IDLE;
      rcnt     <= '0;
      rbit     <= '0;
      rsh      <= '0;
      bad1     <= 1'b0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      rs1      <= rxd;
      rs2      <= rs1;
      rx_ready <= 1'b0;
      if (stat_rd) ferr <= 1'b0;
      if (tick) begin
        hist <= {hist[0], rs2};
        if (rst != R_IDLE && rst != R_WAIT) rcnt <= mid ? '0 : rcnt + 1'b1;
      end
      case (rst)
        R_IDLE: if (!rs2) begin
          rst  <= R_START;
          rcnt <= '0;
        end
        R_START: if (mid) begin
          rst  <= vote ? R_IDLE : R_DATA;
          rbit <= '0;
        end
        R_DATA: if (mid) begin
          rsh  <= {vote, rsh[DW-1:1]};
          rbit <= rbit + 1'b1;
          if (rbit == IW'(DW - 1)) rst <= R_STOP1;
        end
        R_STOP1: if (mid) begin
          if (two_stop) begin
            bad1 <= !vote;
            rst  <= R_STOP2;
          end else begin
            rx_data  <= rsh;
            rx_ready <= 1'b1;
            if (!vote) ferr <= 1'b1;
            rst <= R_WAIT;
          end
        end
        R_STOP2: if (mid) begin
          rx_data  <= rsh;
          rx_ready <= 1'b1;
          if (!vote || bad1) ferr <= 1'b1;
          rst <= R_WAIT;
        end
        R_WAIT: if (rs2) rst <= R_IDLE;
        default: rst <= R_IDLE;
      endcase
    end
  end
endmodule

module uart_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic stat_rd,
  input logic txd,
  input logic tx_busy,
  input logic tx_ready,
  input logic rx_ready,
  input logic ferr
);
  AST_RX_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) rx_ready |=> !rx_ready); // R9
  AST_TX_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) tx_ready |=> !tx_ready); // R3
  AST_TX_DONE:   assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> (txd && !tx_busy)); // R3
  AST_FERR_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ferr) |-> rx_ready); // R9
  AST_FERR_CLR:  assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> (!ferr || rx_ready)); // R10
  AST_FERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ferr && !stat_rd) |=> ferr); // R10
endmodule

bind uart_framer uart_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .txd(txd), .tx_busy(tx_busy),
  .tx_ready(tx_ready), .rx_ready(rx_ready), .ferr(ferr)
);

// File: tb/uart_framer_tb.sv
module uart_framer_tb;
  logic clk = 0, rst_n = 0;
  logic two_stop = 0, wr_en = 0, stat_rd = 0, tick = 0, rxd = 1;
  logic [7:0] wr_data = 0;
  logic txd, tx_busy, tx_ready, rx_ready, ferr;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  int tdiv = 0;
  bit done = 0;
  logic rd_edge = 0;
  logic fm = 0;
  logic [8:0] expq[$];

  always #10 clk = ~clk;

  uart_framer u_dut (.*);

  always @(negedge clk) begin
    tdiv++;
    tick <= (tdiv % 4 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_edge = stat_rd;

  // behavioural receive model, compared every clock
  always @(negedge clk) if (rst_n) begin
    logic [8:0] e;
    if (rx_ready) begin
      if (expq.size() == 0) chk(0, "R5 unexpected rx_ready", 1, 0);
      else begin
        e = expq.pop_front();
        chk(rx_data == e[7:0], "R9 rx_data", rx_data, e[7:0]);
        if (e[8]) fm = 1;
        else if (rd_edge) fm = 0;
      end
    end else if (rd_edge) fm = 0;
    chk(ferr == fm, "R10 ferr", ferr, fm);
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic two, input bit poke);
    logic [11:0] bits;
    int nb;
    bits = {2'b11, d, 1'b0};
    nb = 10 + two;
    @(negedge clk); two_stop = two; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    chk(txd == 0, "R2 start on next clock", txd, 0);
    for (int b = 0; b < nb; b++) begin
      wait_ticks(8);
      @(negedge clk);
      chk(txd == bits[b], b < 9 ? "R2 tx bit" : "R3 tx stop", txd, bits[b]);
      chk(tx_ready == 0, "R3 no early tx_ready", tx_ready, 0);
      if (poke && b == 3) begin
        wr_en = 1; wr_data = 8'hFF;
        @(negedge clk); wr_en = 0;
      end
      wait_ticks(8);
    end
    @(negedge clk);
    chk(tx_ready == 1, "R3 tx_ready", tx_ready, 1);
    chk(tx_busy == 0, "R3 tx_busy cleared", tx_busy, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic s1, input logic s2,
                          input int nstop, input int glitch);
    logic [10:0] bits;
    bits = {s2, s1, d, 1'b0};
    for (int b = 0; b < 9 + nstop; b++) begin
      @(negedge clk); rxd = bits[b];
      if (b == glitch) begin
        wait_ticks(7); @(negedge clk); rxd = ~bits[b];
        wait_ticks(1); @(negedge clk); rxd = bits[b];
        wait_ticks(8);
      end else wait_ticks(16);
    end
    @(negedge clk); rxd = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1 txd idle", txd, 1);
    chk(ferr == 0, "R1 ferr", ferr, 0);
    chk(tx_busy == 0, "R1 tx_busy", tx_busy, 0);
    chk(tx_ready == 0 && rx_ready == 0, "R1 pulses", {tx_ready, rx_ready}, 0);

    tx_frame(8'hA5, 0, 0);
    tx_frame(8'h3C, 1, 1);
    for (int i = 0; i < 40; i++) begin
      wait_ticks(1); @(negedge clk);
      chk(txd == 1 && tx_ready == 0, "R4 write while busy ignored", txd, 1);
    end

    two_stop = 0;
    expq.push_back({1'b0, 8'h5A}); rx_frame(8'h5A, 1, 1, 1, -1);
    wait_ticks(20);
    expq.push_back({1'b0, 8'h81}); rx_frame(8'h81, 1, 1, 1, -1);
    expq.push_back({1'b0, 8'h7E}); rx_frame(8'h7E, 1, 1, 1, -1);
    wait_ticks(20);
    chk(expq.size() == 0, "R7 back-to-back frames received", expq.size(), 0);

    expq.push_back({1'b1, 8'hC3}); rx_frame(8'hC3, 0, 1, 1, -1);
    wait_ticks(20);
    chk(ferr == 1, "R9 ferr after bad stop", ferr, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk(ferr == 0, "R10 cleared by read", ferr, 0);

    two_stop = 1;
    expq.push_back({1'b0, 8'h96}); rx_frame(8'h96, 1, 1, 2, -1);
    wait_ticks(20);
    expq.push_back({1'b1, 8'h11}); rx_frame(8'h11, 1, 0, 2, -1);
    wait_ticks(20);
    chk(ferr == 1, "R8 second stop checked", ferr, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    expq.push_back({1'b1, 8'h22}); rx_frame(8'h22, 0, 1, 2, -1);
    wait_ticks(20);
    chk(ferr == 1, "R8 first stop checked", ferr, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;

    @(negedge clk); rxd = 0; wait_ticks(2); @(negedge clk); rxd = 1;
    wait_ticks(40);
    chk(expq.size() == 0, "R5 short low pulse rejected", expq.size(), 0);
    expq.push_back({1'b0, 8'h44}); rx_frame(8'h44, 1, 1, 2, -1);
    wait_ticks(20);
    expq.push_back({1'b0, 8'hF0}); rx_frame(8'hF0, 1, 1, 2, 4);
    wait_ticks(20);
    chk(expq.size() == 0, "R6 glitched frame delivered", expq.size(), 0);

    @(negedge clk); stat_rd = 1;
    expq.push_back({1'b1, 8'h99}); rx_frame(8'h99, 1, 0, 2, -1);
    wait_ticks(4);
    @(negedge clk); stat_rd = 0;
    chk(ferr == 0, "R10 clear after set-wins cycle", ferr, 0);
    chk(expq.size() == 0, "R9 all bytes delivered", expq.size(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule